// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device side of an ATA command register set, sitting on an 8-bit I/O port bus with a 3-bit offset. A host writes the sector count, a 24-bit LBA and the device/head byte into task-file registers. It then writes an opcode to the command offset. The block runs a small state machine that answers four commands:

- **IDENTIFY** streams a 256-word parameter block through the data offset.
- **FLUSH CACHE** holds the device busy until an external completion strobe arrives.
- **READ DMA** and **WRITE DMA** hand the transfer to a bus-master engine and wait for its done strobe.

Reads of status and command share one offset. A status read acknowledges the interrupt line.

The states are **IDLE**, **PIO_IN**, **FLUSH** and **DMA**. The transitions are:

- IDLE or PIO_IN to PIO_IN when the identify opcode is written.
- IDLE or PIO_IN to FLUSH when the flush opcode is written.
- IDLE or PIO_IN to DMA when either DMA opcode is written.
- IDLE or PIO_IN to IDLE when an unknown opcode is written.
- PIO_IN to IDLE on the read of the last identify word.
- FLUSH to IDLE on `flush_done`.
- DMA to IDLE on `dma_done`.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40, `irq` is low and `dma_go` is low. The status byte has BSY at bit 7, DRDY at bit 6, DF at bit 5, DRQ at bit 3 and ERR at bit 0.
- R2: Writes to offsets 2 (count), 3/4/5 (LBA bits 7:0, 15:8, 23:16) and 6 (device) read back at the same offset in `io_rdata[7:0]`. The same values appear on `tf_count`, `tf_lba` and `tf_dev`.
- R3: Writing 0xEC to offset 7 puts status at 0x48 (DRDY and DRQ) and raises `irq` on the next clock.
- R4: In PIO_IN, each of 256 reads of offset 0 returns the next identify word while status stays 0x48. Word 0 is 0x0040 and word i>0 is {i, i XOR 0xA5}. After the last read, status is 0x40.
- R5: Writing 0xE7 gives status 0xC0 (BSY and DRDY) until `flush_done` pulses. Status then returns to 0x40 and `irq` rises.
- R6: A read of offset 7 drops `irq` on the following clock, unless a completion event occurs in the same cycle.
- R7: Opcode 0xC8 and opcode 0xCA each raise `dma_go` with status 0xC0. `dma_to_host` is 1 for 0xC8 and 0 for 0xCA. On `dma_done`, `dma_go` falls, status becomes 0x40 and `irq` rises.
- R8: An unknown opcode leaves BSY clear, sets ERR (status 0x41) and raises `irq`. ERR clears on the next known opcode.
- R9: While BSY is set, writes to every offset are ignored, including new opcodes.
- R10: A read of offset 0 outside PIO_IN returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 3 | Task-file offset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access; side effects occur at its clock edge |
| io_rdata | output | 16 | Read data, combinational from `io_addr` |
| flush_done | input | 1 | Cache flush completion strobe |
| dma_done | input | 1 | Bus-master transfer completion strobe |
| dma_go | output | 1 | DMA transfer is owned by the bus-master engine |
| dma_to_host | output | 1 | DMA direction: 1 means device to memory |
| tf_count | output | 8 | Latched sector count |
| tf_lba | output | 24 | Latched LBA |
| tf_dev | output | 8 | Latched device/head byte |
| irq | output | 1 | Pending completion interrupt |

## Verification
A wrong state register shows up at once in the status byte: a DRQ or BSY bit appears in the wrong phase on the next status read. A stuck word counter shows as a mismatched identify word or as DRQ clearing early or late, within one data read of the fault. Busy gating errors show when task-file values change after writes issued during FLUSH or DMA, or when an opcode sneaks in during them. Interrupt faults show on `irq` one clock after a status read or a completion strobe.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_PIO_IN, ST_FLUSH, ST_DMA} tf_state_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_LBA0  = 3'd3;
    localparam logic [2:0] OFS_DEV   = 3'd6;
    localparam logic [2:0] OFS_CMD   = 3'd7;

    localparam logic [7:0] OP_RD_DMA = 8'hC8;
    localparam logic [7:0] OP_WR_DMA = 8'hCA;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;
    localparam logic [7:0] OP_IDENT  = 8'hEC;

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_RD_DMA) || (op == OP_WR_DMA) ||
               (op == OP_FLUSH)  || (op == OP_IDENT);
    endfunction

    function automatic tf_state_e op_target(input logic [7:0] op);
        case (op)
            OP_IDENT:             return ST_PIO_IN;
            OP_FLUSH:             return ST_FLUSH;
            OP_RD_DMA, OP_WR_DMA: return ST_DMA;
            default:              return ST_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
    parameter int LBA_BYTES = 3,
    localparam int LBA_W = LBA_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       count,
    output logic [LBA_W-1:0] lba,
    output logic [7:0]       dev
);
    import ata_tf_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            dev   <= '0;
        end else if (wr_en) begin
            if (addr == OFS_COUNT) count <= wdata;
            if (addr == OFS_DEV)   dev   <= wdata;
        end
    end

    for (genvar b = 0; b < LBA_BYTES; b++) begin : g_lba
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lba[b*8 +: 8] <= '0;
            else if (wr_en && addr == 3'(OFS_LBA0 + b))
                lba[b*8 +: 8] <= wdata;
        end
    end
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    always_comb begin
        if (idx == '0)
            word = 16'h0040;
        else
            word = {8'(idx), 8'(idx) ^ 8'hA5};
    end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl #(
    parameter int IDENT_WORDS = 256,
    parameter int LBA_BYTES = 3,
    localparam int CNT_W = $clog2(IDENT_WORDS),
    localparam int LBA_W = LBA_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    input  logic             io_rd,
    output logic [15:0]      io_rdata,
    input  logic             flush_done,
    input  logic             dma_done,
    output logic             dma_go,
    output logic             dma_to_host,
    output logic [7:0]       tf_count,
    output logic [LBA_W-1:0] tf_lba,
    output logic [7:0]       tf_dev,
    output logic             irq
);
    import ata_tf_pkg::*;

    tf_state_e        state, state_nxt;
    logic [CNT_W-1:0] word_cnt;
    logic             err_q, irq_q, dir_q;
    logic             bsy, drq, tf_wr, cmd_wr, data_rd, stat_rd, last_word, done_evt;
    logic [15:0]      ident_word;
    logic [7:0]       status;

    assign bsy       = (state == ST_FLUSH) || (state == ST_DMA);
    assign drq       = (state == ST_PIO_IN);
    assign tf_wr     = io_wr && !bsy;
    assign cmd_wr    = tf_wr && (io_addr == OFS_CMD);
    assign data_rd   = io_rd && (io_addr == OFS_DATA) && drq;
    assign stat_rd   = io_rd && (io_addr == OFS_CMD);
    assign last_word = (word_cnt == CNT_W'(IDENT_WORDS - 1));
    assign done_evt  = (cmd_wr && (io_wdata == OP_IDENT || !op_known(io_wdata))) ||
                       (state == ST_FLUSH && flush_done) ||
                       (state == ST_DMA && dma_done);

    ata_tf_regs #(.LBA_BYTES(LBA_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(tf_wr), .addr(io_addr), .wdata(io_wdata),
        .count(tf_count), .lba(tf_lba), .dev(tf_dev)
    );

    ata_tf_ident #(.WORDS(IDENT_WORDS)) u_ident (.idx(word_cnt), .word(ident_word));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_PIO_IN: begin
                if (cmd_wr)                   state_nxt = op_target(io_wdata);
                else if (data_rd && last_word) state_nxt = ST_IDLE;
            end
            ST_FLUSH: if (flush_done) state_nxt = ST_IDLE;
            ST_DMA:   if (dma_done)   state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            if (cmd_wr) begin
                word_cnt <= '0;
                err_q    <= !op_known(io_wdata);
                dir_q    <= (io_wdata == OP_RD_DMA);
            end else if (data_rd) begin
                word_cnt <= word_cnt + 1'b1;
            end
            if (done_evt)     irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
        end
    end

    assign status      = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err_q};
    assign irq         = irq_q;
    assign dma_go      = (state == ST_DMA);
    assign dma_to_host = dir_q;

    always_comb begin
        io_rdata = '0;
        case (io_addr)
            OFS_DATA:  io_rdata = drq ? ident_word : 16'h0000;
            OFS_COUNT: io_rdata = {8'h00, tf_count};
            OFS_DEV:   io_rdata = {8'h00, tf_dev};
            OFS_CMD:   io_rdata = {8'h00, status};
            default: begin
                for (int b = 0; b < LBA_BYTES; b++)
                    if (io_addr == 3'(OFS_LBA0 + b)) io_rdata = {8'h00, tf_lba[b*8 +: 8]};
            end
        endcase
    end

    // R4
    ident_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && last_word && !cmd_wr) |=> (state == ST_IDLE));
    // R5
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && !flush_done) |=> (state == ST_FLUSH));
    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done_evt) |=> !irq);
    // R7
    dma_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_go && dma_done) |=> (!dma_go && irq));
    // R8
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !op_known(io_wdata)) |=> (err_q && irq && !bsy));
    // R9
    busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && io_wr) |=> ($stable(tf_lba) && $stable(tf_count) && $stable(tf_dev)));
endmodule

// File: tb/ata_taskfile_ctrl_tb.sv
module ata_taskfile_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] io_rdata;
    logic        flush_done = 1'b0, dma_done = 1'b0;
    logic        dma_go, dma_to_host, irq;
    logic [7:0]  tf_count, tf_dev;
    logic [23:0] tf_lba;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_rdata(io_rdata), .flush_done(flush_done), .dma_done(dma_done),
        .dma_go(dma_go), .dma_to_host(dma_to_host), .tf_count(tf_count), .tf_lba(tf_lba),
        .tf_dev(tf_dev), .irq(irq)
    );

    function automatic logic [15:0] exp_word(input int i);
        if (i == 0) return 16'h0040;
        return {8'(i), 8'(i) ^ 8'hA5};
    endfunction

    function automatic logic [7:0] exp_status(input bit b, input bit q, input bit e);
        return {b, 1'b1, 1'b0, 1'b0, q, 2'b00, e};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
    endtask

    task automatic pulse_dma();
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  v;
        logic [7:0]  ex_regs [2:6];
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 dma_go", dma_go, 0);
        rd(3'd7, d); chk("R1 status", d, 16'h0040);

        // R2 random register writes with readback
        for (int k = 0; k < 6; k++) ex_regs[2 + (k % 5)] = 8'h00;
        for (int n = 0; n < 30; n++) begin
            int a;
            a = 2 + int'($urandom_range(0, 4));
            v = 8'($urandom);
            wr(3'(a), v);
            ex_regs[a] = v;
            rd(3'(a), d); chk("R2 readback", d, {8'h00, v});
        end
        chk("R2 count", tf_count, ex_regs[2]);
        chk("R2 lba", tf_lba, {ex_regs[5], ex_regs[4], ex_regs[3]});
        chk("R2 dev", tf_dev, ex_regs[6]);
        wr(3'd6, 8'h00); rd(3'd6, d); chk("R2 dev zero", d[4], 0);
        ex_regs[6] = 8'h00;

        // R10 data read outside PIO
        rd(3'd0, d); chk("R10 idle data", d, 0);
        rd(3'd7, d); chk("R10 status", d, 16'h0040);

        // R3 identify
        wr(3'd7, 8'hEC);
        chk("R3 irq", irq, 1);
        rd(3'd7, d); chk("R3 status", d, {8'h00, exp_status(0, 1, 0)});
        chk("R6 irq cleared", irq, 0);
        // R4 data-in words
        for (int i = 0; i < 256; i++) begin
            rd(3'd0, d); chk("R4 word", d, exp_word(i));
            if (i % 37 == 0 || i == 254) begin
                rd(3'd7, d); chk("R4 drq held", d, 16'h0048);
            end
        end
        rd(3'd7, d); chk("R4 drq end", d, 16'h0040);
        rd(3'd0, d); chk("R10 after pio", d, 0);

        // R5 flush with R9 busy writes
        wr(3'd7, 8'hE7);
        rd(3'd7, d); chk("R5 busy", d, 16'h00C0);
        wr(3'd3, 8'h5A ^ ex_regs[3]);
        wr(3'd7, 8'hEC);
        repeat (5) @(negedge clk);
        rd(3'd7, d); chk("R5 still busy", d, 16'h00C0);
        chk("R5 no irq", irq, 0);
        pulse_flush();
        chk("R5 irq", irq, 1);
        rd(3'd7, d); chk("R9 opcode ignored", d, 16'h0040);
        rd(3'd3, d); chk("R9 lba unchanged", d, {8'h00, ex_regs[3]});
        chk("R6 irq cleared", irq, 0);

        // R7 DMA both directions
        for (int n = 0; n < 4; n++) begin
            bit rdir;
            rdir = (n % 2 == 0);
            wr(3'd7, rdir ? 8'hC8 : 8'hCA);
            chk("R7 go", dma_go, 1);
            chk("R7 dir", dma_to_host, rdir);
            rd(3'd7, d); chk("R7 busy", d, 16'h00C0);
            wr(3'd2, ~ex_regs[2]);
            repeat (int'($urandom_range(1, 8))) @(negedge clk);
            chk("R7 go held", dma_go, 1);
            pulse_dma();
            chk("R7 go end", dma_go, 0);
            chk("R7 irq", irq, 1);
            rd(3'd7, d); chk("R7 status end", d, 16'h0040);
            chk("R9 count", tf_count, ex_regs[2]);
        end

        // R8 unknown opcode
        wr(3'd7, 8'h55);
        chk("R8 irq", irq, 1);
        chk("R8 no dma", dma_go, 0);
        rd(3'd7, d); chk("R8 status", d, 16'h0041);
        wr(3'd7, 8'hE7);
        rd(3'd7, d); chk("R8 err cleared", d, 16'h00C0);
        pulse_flush();

        // R6 completion in same cycle as status read keeps irq
        wr(3'd7, 8'hE7);
        @(negedge clk);
        io_addr = 3'd7; io_rd = 1'b1; flush_done = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; flush_done = 1'b0;
        chk("R6 set wins", irq, 1);
        rd(3'd7, d);
        chk("R6 irq cleared", irq, 0);

        finish_run();
    end
endmodule